// File: doc/BRIEF.md
# Conditional Input Instruction Sequencer

This block is the processor-side control for an I/O instruction that moves a word from a peripheral into the accumulator and may skip the following instruction. When the decoder hands it an instruction with `start`, it places the device address and an input-command level on the I/O bus. It then waits for those lines to settle, and samples a shared active-low ready line that the addressed device drives.

The accumulator is cleared on every execution. If the device holds the ready line low, the sequencer loads the data bus into the accumulator. It then issues a one-cycle active-low strobe, which the device may use to reset its ready flag, and returns a program counter advanced by two. If the line is high, nothing is loaded, no strobe appears, and the program counter advances by one. Completion is signalled with a single-cycle `done`, in the same cycle that the address and command are withdrawn.

Top module: `condInputSeq`

## Requirements
- R1: While reset is held and after its release, `inCmd` is 0, `strobeN` is 1, `done` is 0 and `acc` is 0.
- R2: A `start` seen while idle puts `devAddr` on `ioAddr` and raises `inCmd` from the next cycle. Both hold until the cycle in which `done` is high.
- R3: The ready line and the data bus are sampled only at the third rising edge after the start edge (a 2-cycle settle interval). Values on them before that edge have no effect.
- R4: The cycle after the start edge, `acc` reads 0, whatever its earlier value and whatever the ready line does.
- R5: If `readyN` is 0 at the sampling edge, `acc` holds the sampled `dataBus` value from the next cycle on.
- R6: On the ready path, `strobeN` is 0 for exactly one cycle. That cycle is the one after the cycle in which `acc` first shows the loaded data, and `inCmd` is still 1 during it.
- R7: If `readyN` is 1 at the sampling edge, `strobeN` never goes low, `acc` stays 0, and `done` rises in the cycle right after the sampling edge with `pcOut` = `pcIn` + 1.
- R8: On the ready path, `done` rises in the cycle after the strobe with `pcOut` = `pcIn` + 2, wrapping modulo 2^PC_W.
- R9: `done` is high for exactly one cycle, and `inCmd` is 0 in that cycle.
- R10: A `start` that arrives while an instruction is in progress is ignored. `ioAddr` and the timing of the running instruction are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Decoded input instruction, one-cycle request |
| pcIn | input | PC_W | Address of the current instruction |
| devAddr | input | ADDR_W | Device address field of the instruction |
| dataBus | input | DATA_W | Input data bus driven by the device |
| readyN | input | 1 | Shared active-low ready/test line |
| ioAddr | output | ADDR_W | Device address placed on the I/O bus |
| inCmd | output | 1 | Input command level |
| strobeN | output | 1 | Active-low one-cycle strobe |
| acc | output | DATA_W | Accumulator |
| pcOut | output | PC_W | Next program counter, valid with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `start` is a single-cycle request. They also assume that `pcIn` and `devAddr` are meaningful only in the cycle of that request. The bench drives `start` for exactly one cycle and changes stimulus only on falling clock edges. It toggles `readyN` and `dataBus` randomly during the settle cycles, to show that only the sampling edge counts. It also fires a second `start` partway through some instructions, so that the busy case stays inside the single-pulse assumption.

// File: rtl/condInputPkg.sv
package condInputPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_SAMPLE,
    ST_LOADED,
    ST_STROBE,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic capture;  // latch pc/address, clear accumulator
    logic loadAcc;  // take the data bus into the accumulator
    logic setPc;    // compute the next program counter
    logic skip;     // advance by two instead of one
  } seqCtl_t;
endpackage

// File: rtl/condInputCtl.sv
module condInputCtl
  import condInputPkg::*;
#(
  parameter int SETTLE = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    readyN,
  output seqCtl_t ctl,
  output logic    inCmd,
  output logic    strobeN,
  output logic    done
);
  localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);

  seqState_t state, stateNext;
  logic [CNT_W-1:0] settleCnt;

  always_comb begin
    stateNext = state;
    ctl = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        stateNext = ST_SETTLE;
        ctl.capture = 1'b1;
      end
      ST_SETTLE: if (settleCnt == CNT_LAST) stateNext = ST_SAMPLE;
      ST_SAMPLE: begin
        ctl.setPc = 1'b1;
        if (!readyN) begin
          ctl.loadAcc = 1'b1;
          ctl.skip = 1'b1;
          stateNext = ST_LOADED;
        end else begin
          stateNext = ST_DONE;
        end
      end
      ST_LOADED: stateNext = ST_STROBE;
      ST_STROBE: stateNext = ST_DONE;
      ST_DONE:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      settleCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_SETTLE) settleCnt <= settleCnt + 1'b1;
      else settleCnt <= '0;
    end
  end

  assign inCmd = (state == ST_SETTLE) || (state == ST_SAMPLE) ||
                 (state == ST_LOADED) || (state == ST_STROBE);
  assign strobeN = (state != ST_STROBE);
  assign done = (state == ST_DONE);

  // R6
  strobe_with_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobeN |-> inCmd);
  // R6
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobeN |=> strobeN);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !inCmd);
  // R3
  sample_after_settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setPc |-> ($past(inCmd, 1) && $past(inCmd, 2)));
endmodule

// File: rtl/condInputData.sv
module condInputData
  import condInputPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int PC_W   = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic [DATA_W-1:0] dataBus,
  output logic [ADDR_W-1:0] ioAddr,
  output logic [DATA_W-1:0] acc,
  output logic [PC_W-1:0]   pcOut
);
  localparam logic [PC_W-1:0] STEP_ONE = PC_W'(1);
  localparam logic [PC_W-1:0] STEP_TWO = PC_W'(2);

  logic [PC_W-1:0] pcHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
      pcHold <= '0;
      pcOut <= '0;
      ioAddr <= '0;
    end else begin
      if (ctl.capture) begin
        acc <= '0;
        pcHold <= pcIn;
        ioAddr <= devAddr;
      end else if (ctl.loadAcc) begin
        acc <= dataBus;
      end
      if (ctl.setPc) pcOut <= pcHold + (ctl.skip ? STEP_TWO : STEP_ONE);
    end
  end

  // R4
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (acc == '0));
  // R7
  noload_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.setPc && !ctl.skip) |=> (acc == '0));
endmodule

// File: rtl/condInputSeq.sv
module condInputSeq
  import condInputPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int PC_W   = 15,
  parameter int SETTLE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic [DATA_W-1:0] dataBus,
  input  logic              readyN,
  output logic [ADDR_W-1:0] ioAddr,
  output logic              inCmd,
  output logic              strobeN,
  output logic [DATA_W-1:0] acc,
  output logic [PC_W-1:0]   pcOut,
  output logic              done
);
  seqCtl_t ctl;

  condInputCtl #(.SETTLE(SETTLE)) uCtl (
    .clk(clk), .rstN(rstN), .start(start), .readyN(readyN),
    .ctl(ctl), .inCmd(inCmd), .strobeN(strobeN), .done(done)
  );

  condInputData #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PC_W(PC_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pcIn(pcIn), .devAddr(devAddr),
    .dataBus(dataBus), .ioAddr(ioAddr), .acc(acc), .pcOut(pcOut)
  );

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inCmd && $past(inCmd)) |-> $stable(ioAddr));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inCmd |-> strobeN);
endmodule

// File: tb/sim_condInputSeq.sv
module sim_condInputSeq;
  localparam int DW = 16, AW = 6, PW = 15;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, readyN = 1'b1;
  logic [PW-1:0] pcIn = '0;
  logic [AW-1:0] devAddr = '0;
  logic [DW-1:0] dataBus = '0;
  logic [AW-1:0] ioAddr;
  logic inCmd, strobeN, done;
  logic [DW-1:0] acc;
  logic [PW-1:0] pcOut;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  condInputSeq u0 (
    .clk(clk), .rstN(rstN), .start(start), .pcIn(pcIn), .devAddr(devAddr),
    .dataBus(dataBus), .readyN(readyN), .ioAddr(ioAddr), .inCmd(inCmd),
    .strobeN(strobeN), .acc(acc), .pcOut(pcOut), .done(done)
  );

  function automatic logic [PW-1:0] nextPc(logic [PW-1:0] pc, bit hit);
    return pc + (hit ? PW'(2) : PW'(1));
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One instruction; begins on a falling edge, returns on a falling edge.
  task automatic runInstr(logic [PW-1:0] pc, logic [AW-1:0] addr,
                          logic [DW-1:0] data, bit hit, bit noise, bit busyStart);
    pcIn = pc; devAddr = addr; start = 1'b1;
    step();  // start edge
    start = 1'b0; pcIn = ~pc; devAddr = ~addr;
    chk("R4", "acc cleared", acc, 0);
    chk("R2", "inCmd raised", inCmd, 1);
    chk("R2", "ioAddr", ioAddr, addr);
    if (noise) begin readyN = $urandom; dataBus = $urandom; end
    else begin readyN = ~hit; dataBus = ~data; end
    if (busyStart) start = 1'b1;
    step();  // settle edge 1
    start = 1'b0;
    chk("R10", "ioAddr kept", ioAddr, addr);
    chk("R2", "inCmd held", inCmd, 1);
    if (noise) begin readyN = $urandom; dataBus = $urandom; end
    step();  // settle edge 2
    chk("R3", "no early done", done, 0);
    readyN = ~hit; dataBus = data;
    step();  // sampling edge
    readyN = $urandom; dataBus = $urandom;
    if (hit) begin
      chk("R5", "acc loaded", acc, data);
      chk("R6", "strobe not yet", strobeN, 1);
      chk("R8", "no done yet", done, 0);
      step();
      chk("R6", "strobe low", strobeN, 0);
      chk("R6", "cmd during strobe", inCmd, 1);
      chk("R5", "acc kept", acc, data);
      step();
      chk("R6", "strobe one cycle", strobeN, 1);
      chk("R8", "done after strobe", done, 1);
      chk("R8", "pc plus two", pcOut, nextPc(pc, 1'b1));
      chk("R9", "cmd released", inCmd, 0);
    end else begin
      chk("R7", "done at once", done, 1);
      chk("R7", "no strobe", strobeN, 1);
      chk("R7", "acc zero", acc, 0);
      chk("R7", "pc plus one", pcOut, nextPc(pc, 1'b0));
      chk("R9", "cmd released", inCmd, 0);
    end
    step();
    chk("R9", "done one cycle", done, 0);
    chk("R10", "idle after busy start", inCmd, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (2) @(negedge clk);
    chk("R1", "inCmd in reset", inCmd, 0);
    chk("R1", "strobe in reset", strobeN, 1);
    rstN = 1'b1;
    step();
    chk("R1", "inCmd idle", inCmd, 0);
    chk("R1", "strobe idle", strobeN, 1);
    chk("R1", "done idle", done, 0);
    chk("R1", "acc idle", acc, 0);
    // directed corners
    runInstr(15'h0010, 6'h05, 16'hBEEF, 1'b1, 1'b0, 1'b0);
    runInstr(15'h0020, 6'h3F, 16'h1234, 1'b0, 1'b1, 1'b0);  // acc cleared from BEEF
    runInstr(15'h7FFF, 6'h00, 16'hFFFF, 1'b1, 1'b1, 1'b1);  // R8 wrap
    runInstr(15'h7FFE, 6'h21, 16'h0001, 1'b1, 1'b0, 1'b0);  // R8 wrap to 0
    runInstr(15'h7FFF, 6'h11, 16'h0000, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 60; i++) begin
      runInstr(PW'($urandom), AW'($urandom), DW'($urandom),
               bit'($urandom), bit'($urandom), bit'($urandom));
      repeat ($urandom_range(0, 2)) step();
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule